// File: doc/BRIEF.md
# Calendar Alarm Comparator

This block watches a running calendar and raises an alarm interrupt when the time reaches a programmed value. It holds one control register and six alarm registers in BCD: seconds, minutes, hours, day of month, month, and a three-digit year. A separate calendar counter supplies the current time fields and a one-cycle strobe each time the time advances by one second. The block does not count time itself.

On each strobe the block compares every enabled field with its alarm register, using the time fields presented with that strobe. A match on any one enabled field is enough; the per-field results are ORed together, not ANDed. A match sets a sticky pending flag, and that flag drives the interrupt output. Software clears the flag by writing a 1 to status bit 1.

Software reaches the registers through a simple register port. A write is one cycle of `wr_en` with a selector and data. Reads are combinational on `rd_sel`.

Top module: `cal_alarm_top`

## Requirements
- R1: After reset, the control register, all six alarm registers and the pending flag are 0, and `alarm_irq` is low.
- R2: The selector codes are: 0 control, 1 seconds, 2 minutes, 3 hours, 4 day, 5 month, 6 year, 7 status. A write stores only the low bits of `wr_data`: 7 bits for control, seconds and minutes; 6 bits for hours and day; 5 bits for month; 12 bits for year. Reading a register returns the stored value zero-extended to 12 bits.
- R3: Control bits 0 to 5 enable the comparison of seconds, minutes, hours, day, month and year, in that order. A field whose enable bit is clear never causes a match.
- R4: Control bit 6 is the global alarm enable. While it is clear, a strobe never sets the pending flag.
- R5: The alarm fires when at least one enabled field equals its alarm register (OR of the fields). An 8-bit time field is compared with its alarm register zero-extended.
- R6: The comparison happens only in a cycle where `sec_tick` is high, using the time inputs of that same cycle. The pending flag and `alarm_irq` rise on the following clock edge. Without a strobe, the flag never rises.
- R7: The year comparison uses all 12 bits: the hundreds digit in bits 11:8 and the low two digits in bits 7:0.
- R8: The status register reads the pending flag in bit 1, with all other bits 0. Writing status with bit 1 set clears the flag and lowers `alarm_irq` on the next edge. Writing status with bit 1 clear changes nothing.
- R9: The pending flag stays set across further matches until it is cleared. When a match and a clear happen in the same cycle, the match wins and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write register selector |
| wr_data | input | 12 | Write data |
| rd_sel | input | 3 | Read register selector |
| rd_data | output | 12 | Read data, combinational on rd_sel |
| sec_tick | input | 1 | One-cycle strobe: time has just advanced by one second |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD |
| now_mday | input | 8 | Current day of month, BCD |
| now_mon | input | 8 | Current month, BCD |
| now_year | input | 12 | Current year, three BCD digits |
| alarm_irq | output | 1 | Alarm interrupt, equal to the pending flag |

## Verification
The assertions assume that `sec_tick` is the only event that can set the flag, and that a status write is the only event that can clear it. They also assume that the time fields are stable in the strobe cycle. The bench changes the time inputs and asserts `sec_tick` together at the falling edge. It drives no write in a strobe cycle except in the one test that checks a match and a clear in the same cycle. The stimulus also presents matching time values with no strobe and with the global enable off, so that both gates are exercised at the ports.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int NUM_FIELDS  = 6;
  localparam int FIELD_MAX_W = 12;
  localparam int CTRL_W      = 7;
  localparam int GLB_EN_BIT  = 6;
  localparam int PEND_BIT    = 1;

  typedef enum logic [2:0] {
    SEL_CTRL = 3'd0,
    SEL_SEC  = 3'd1,
    SEL_MIN  = 3'd2,
    SEL_HOUR = 3'd3,
    SEL_DAY  = 3'd4,
    SEL_MON  = 3'd5,
    SEL_YEAR = 3'd6,
    SEL_STAT = 3'd7
  } reg_sel_e;

  // Stored width of each alarm field, index 0 = seconds .. 5 = year.
  function automatic int field_width(input int idx);
    case (idx)
      0, 1:    field_width = 7;
      2, 3:    field_width = 6;
      4:       field_width = 5;
      default: field_width = 12;
    endcase
  endfunction
endpackage

// File: rtl/cal_alarm_regs.sv
module cal_alarm_regs
  import cal_alarm_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     wr_en,
  input  logic [2:0]                               wr_sel,
  input  logic [DATA_W-1:0]                        wr_data,
  output logic [CTRL_W-1:0]                        ctl_q,
  output logic [NUM_FIELDS-1:0][FIELD_MAX_W-1:0]   alm_q
);
  logic [CTRL_W-1:0] ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en && (wr_sel == SEL_CTRL)) ctl_d = wr_data[CTRL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
    localparam int W = field_width(gi);
    logic [W-1:0] fq, fd;
    logic         we;

    assign we = wr_en && (wr_sel == 3'(gi + 1));

    always_comb begin
      fd = fq;
      if (we) fd = wr_data[W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fq <= '0;
      else        fq <= fd;
    end

    assign alm_q[gi] = FIELD_MAX_W'(fq);
  end
endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
  import cal_alarm_pkg::*;
(
  input  logic [CTRL_W-1:0]                       ctl,
  input  logic [NUM_FIELDS-1:0][FIELD_MAX_W-1:0]  alm,
  input  logic [NUM_FIELDS-1:0][FIELD_MAX_W-1:0]  now,
  output logic                                    hit
);
  logic [NUM_FIELDS-1:0] eq;

  for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_eq
    assign eq[gi] = ctl[gi] && (now[gi] == alm[gi]);
  end

  assign hit = ctl[GLB_EN_BIT] && (|eq);
endmodule

// File: rtl/cal_alarm_pend.sv
module cal_alarm_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_q
);
  logic pend_d;

  always_comb begin
    pend_d = pend_q;
    if (clr_i) pend_d = 1'b0;
    if (set_i) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  // R9
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clr_i) |=> pend_q);

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> pend_q);

  // R8
  clr_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !pend_q);
endmodule

// File: rtl/cal_alarm_top.sv
module cal_alarm_top
  import cal_alarm_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  input  logic              sec_tick,
  input  logic [7:0]        now_sec,
  input  logic [7:0]        now_min,
  input  logic [7:0]        now_hour,
  input  logic [7:0]        now_mday,
  input  logic [7:0]        now_mon,
  input  logic [11:0]       now_year,
  output logic              alarm_irq
);
  logic [CTRL_W-1:0]                      ctl_q;
  logic [NUM_FIELDS-1:0][FIELD_MAX_W-1:0] alm_q;
  logic [NUM_FIELDS-1:0][FIELD_MAX_W-1:0] now_f;
  logic                                   hit;
  logic                                   set_pend;
  logic                                   clr_pend;
  logic                                   pend_q;

  assign now_f[0] = FIELD_MAX_W'(now_sec);
  assign now_f[1] = FIELD_MAX_W'(now_min);
  assign now_f[2] = FIELD_MAX_W'(now_hour);
  assign now_f[3] = FIELD_MAX_W'(now_mday);
  assign now_f[4] = FIELD_MAX_W'(now_mon);
  assign now_f[5] = now_year;

  cal_alarm_regs #(.DATA_W(DATA_W)) regs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .ctl_q   (ctl_q),
    .alm_q   (alm_q)
  );

  cal_alarm_cmp cmp_i (
    .ctl (ctl_q),
    .alm (alm_q),
    .now (now_f),
    .hit (hit)
  );

  assign set_pend = sec_tick && hit;
  assign clr_pend = wr_en && (wr_sel == SEL_STAT) && wr_data[PEND_BIT];

  cal_alarm_pend pend_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_pend),
    .clr_i  (clr_pend),
    .pend_q (pend_q)
  );

  assign alarm_irq = pend_q;

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      SEL_CTRL: rd_data = DATA_W'(ctl_q);
      SEL_SEC:  rd_data = DATA_W'(alm_q[0]);
      SEL_MIN:  rd_data = DATA_W'(alm_q[1]);
      SEL_HOUR: rd_data = DATA_W'(alm_q[2]);
      SEL_DAY:  rd_data = DATA_W'(alm_q[3]);
      SEL_MON:  rd_data = DATA_W'(alm_q[4]);
      SEL_YEAR: rd_data = DATA_W'(alm_q[5]);
      default:  rd_data[PEND_BIT] = pend_q;
    endcase
  end

  // R4
  glb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_irq) |-> $past(sec_tick && ctl_q[GLB_EN_BIT]));

  // R6
  no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !alarm_irq) |=> !alarm_irq);

  // R2
  mon_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == SEL_MON) |-> (rd_data[DATA_W-1:5] == '0));

  // R8
  stat_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == SEL_STAT) |-> (rd_data[PEND_BIT] == alarm_irq && $countones(rd_data) <= 1));
endmodule

// File: tb/cal_alarm_top_tb_top.sv
module cal_alarm_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_sel;
  logic [11:0] wr_data;
  logic [2:0]  rd_sel;
  logic [11:0] rd_data;
  logic        sec_tick;
  logic [7:0]  now_sec, now_min, now_hour, now_mday, now_mon;
  logic [11:0] now_year;
  logic        alarm_irq;

  always #5 clk = ~clk;

  cal_alarm_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .sec_tick(sec_tick),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
    .now_mday(now_mday), .now_mon(now_mon), .now_year(now_year),
    .alarm_irq(alarm_irq)
  );

  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 0;
  string cur_req = "R1";

  // Behavioural reference state
  int m_ctl;
  int m_alm[6];
  int m_pend;
  int m_mask[6] = '{'h7f, 'h7f, 'h3f, 'h3f, 'h1f, 'hfff};

  function automatic int m_read(input int sel);
    if (sel == 0) return m_ctl;
    if (sel == 7) return m_pend * 2;
    return m_alm[sel-1];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    int nowv[6];
    bit any;
    nowv = '{int'(now_sec), int'(now_min), int'(now_hour), int'(now_mday),
             int'(now_mon), int'(now_year)};
    any = 0;
    for (int i = 0; i < 6; i++)
      if (((m_ctl >> i) & 1) != 0 && nowv[i] == m_alm[i]) any = 1;
    if (wr_en) begin
      if (wr_sel == 0) m_ctl = int'(wr_data) & 'h7f;
      else if (wr_sel == 7) begin
        if (wr_data[1]) m_pend = 0;
      end else m_alm[wr_sel-1] = int'(wr_data) & m_mask[wr_sel-1];
    end
    if (sec_tick && ((m_ctl >> 6) & 1) != 0 && any) m_pend = 1;
  endtask

  // One clock: model follows the edge, outputs compared at the falling edge.
  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(cur_req, int'(alarm_irq), m_pend);
    chk(cur_req, int'(rd_data), m_read(int'(rd_sel)));
  endtask

  task automatic wr(input int sel, input int d);
    wr_en = 1; wr_sel = 3'(sel); wr_data = 12'(d);
    step();
    wr_en = 0;
  endtask

  task automatic set_now(input int s, input int mi, input int h, input int d,
                         input int mo, input int y);
    now_sec = 8'(s); now_min = 8'(mi); now_hour = 8'(h);
    now_mday = 8'(d); now_mon = 8'(mo); now_year = 12'(y);
  endtask

  task automatic tick();
    sec_tick = 1;
    step();
    sec_tick = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_sel = 0; wr_data = 0; rd_sel = 0; sec_tick = 0;
    set_now(0, 0, 0, 1, 1, 0);
    m_ctl = 0; m_pend = 0;
    for (int i = 0; i < 6; i++) m_alm[i] = 0;
    repeat (3) @(negedge clk);
    // R1: reset values on every selector
    for (int s = 0; s < 8; s++) begin
      rd_sel = 3'(s); #1;
      chk("R1", int'(rd_data), 0);
    end
    chk("R1", int'(alarm_irq), 0);
    rst_n = 1;
    step();

    // R2: masking on each register
    cur_req = "R2";
    for (int s = 0; s < 7; s++) begin
      rd_sel = 3'(s);
      wr(s, 'hfff);
      step();
    end
    rd_sel = 3'd1; #1; chk("R2", int'(rd_data), 'h7f);
    rd_sel = 3'd3; #1; chk("R2", int'(rd_data), 'h3f);
    rd_sel = 3'd5; #1; chk("R2", int'(rd_data), 'h1f);
    rd_sel = 3'd6; #1; chk("R2", int'(rd_data), 'hfff);
    rd_sel = 3'd0; #1; chk("R2", int'(rd_data), 'h7f);

    // Program alarm: 12:30:45, day 15, month 6, year 0x123
    wr(0, 0);
    wr(1, 'h45); wr(2, 'h30); wr(3, 'h12); wr(4, 'h15); wr(5, 'h06); wr(6, 'h123);
    rd_sel = 3'd7;

    // R4: seconds enabled, global off
    cur_req = "R4";
    wr(0, 'h01);
    set_now('h45, 0, 0, 1, 1, 0);
    tick(); step();
    chk("R4", int'(alarm_irq), 0);

    // R6: global on, matching time but no strobe
    cur_req = "R6";
    wr(0, 'h41);
    step(); step();
    chk("R6", int'(alarm_irq), 0);
    tick();
    chk("R6", int'(alarm_irq), 1);

    // R8: write 0 in bit 1 leaves flag, write bit 1 clears
    cur_req = "R8";
    wr(7, 'h1);
    chk("R8", int'(alarm_irq), 1);
    chk("R8", int'(rd_data), 2);
    wr(7, 'h2);
    chk("R8", int'(alarm_irq), 0);

    // R9: sticky across ticks without a match, and set wins over clear
    cur_req = "R9";
    tick();
    set_now('h46, 0, 0, 1, 1, 0);
    tick(); tick();
    chk("R9", int'(alarm_irq), 1);
    set_now('h45, 0, 0, 1, 1, 0);
    sec_tick = 1; wr(7, 'h2); sec_tick = 0;
    chk("R9", int'(alarm_irq), 1);
    wr(7, 'h2);
    chk("R9", int'(alarm_irq), 0);

    // R3: matching field disabled does not fire
    cur_req = "R3";
    wr(0, 'h42);
    set_now('h45, 'h31, 0, 1, 1, 0);
    tick();
    chk("R3", int'(alarm_irq), 0);

    // R5: minutes and hours enabled, only hours match
    cur_req = "R5";
    wr(0, 'h46);
    set_now('h45, 'h31, 'h12, 1, 1, 0);
    tick();
    chk("R5", int'(alarm_irq), 1);
    wr(7, 'h2);
    // R5: 8-bit time with bit 7 set never equals 7-bit alarm
    wr(1, 'h45); wr(0, 'h41);
    set_now('hc5, 0, 0, 1, 1, 0);
    tick();
    chk("R5", int'(alarm_irq), 0);

    // R3: day and month fields
    cur_req = "R3";
    wr(0, 'h48);
    set_now(0, 0, 0, 'h15, 1, 0);
    tick();
    chk("R3", int'(alarm_irq), 1);
    wr(7, 'h2);
    wr(0, 'h50);
    set_now(0, 0, 0, 1, 'h06, 0);
    tick();
    chk("R3", int'(alarm_irq), 1);
    wr(7, 'h2);

    // R7: year uses the hundreds digit
    cur_req = "R7";
    wr(0, 'h60);
    set_now(0, 0, 0, 1, 1, 'h023);
    tick();
    chk("R7", int'(alarm_irq), 0);
    set_now(0, 0, 0, 1, 1, 'h123);
    tick();
    chk("R7", int'(alarm_irq), 1);
    wr(7, 'h2);

    // R4: clearing global enable stops all matches
    cur_req = "R4";
    wr(0, 'h3f);
    tick();
    chk("R4", int'(alarm_irq), 0);

    repeat (3) step();
    finish_run();
  end
endmodule